// File: doc/BRIEF.md
# Frequency Rollback Watchdog

This block guards a clock generator against a hang that follows a bad frequency setting. Software loads an 8-bit period, counted in 250 ms ticks, and sets the enable. The count then runs down, and software rewrites the period from time to time to keep the system alive. If the count ever reaches zero, the block does three things: it pulls an open-drain system reset line low for one tick period, it sets a sticky timeout flag, and it issues a single-cycle rollback command. That command carries a known-good frequency code and tells the frequency selector to leave divider-programmed mode and return to table mode.

The rollback code comes from one of two sources. One is the strap code latched at power-up. The other is a programmed safe code, chosen by a select input. The live count and the running state can be read at any time. The tick length is a parameter given in clock cycles, so a fast time base can stand in for 250 ms.

Top module: `freq_watchdog`

## Requirements
- R1: After reset the timer reads 8, running and timeout are 0, the reset pull is released and no rollback is issued.
- R2: While running, the count drops by exactly one every TICK_CYCLES clock cycles, and `count_o` always shows the live value.
- R3: `running_o` is 1 from the edge that starts the timer until the count expires or the timer is stopped, and 0 otherwise.
- R4: The timeout flag is set on the edge where the count reaches zero. It stays set until the next successful start, which clears it.
- R5: On expiry `rst_pull_o` is 1 for exactly TICK_CYCLES*PULSE_TICKS cycles, starting at the expiry edge. At all other times it is 0, meaning the line is released (high impedance) and never driven high.
- R6: The rollback code equals `strap_code` when `safe_sel` is 0 and `safe_code` when `safe_sel` is 1, sampled at expiry.
- R7: `rollback_o` is a single-cycle pulse, issued only at expiry. It commands the frequency selector to clear divider-programmed mode and load the rollback code.
- R8: Writing the period while the timer runs reloads the count with the written value and restarts the current tick period, with no expiry.
- R9: Writing the enable with 0 stops the timer. The count holds, and no timeout, reset pull or rollback follows.
- R10: A start request with a period of zero is ignored, and the timer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable value: 1 starts, 0 stops |
| load_wr | input | 1 | Write strobe for the period register |
| load_wdata | input | CNT_W | Period in ticks |
| safe_sel | input | 1 | Rollback source: 0 = straps, 1 = safe code |
| safe_code | input | CODE_W | Programmed safe frequency code |
| strap_code | input | CODE_W | Frequency code latched from straps |
| count_o | output | CNT_W | Live count |
| running_o | output | 1 | Timer is counting |
| timeout_o | output | 1 | Sticky expiry flag |
| rst_pull_o | output | 1 | 1 = pull the open-drain reset line low |
| rollback_o | output | 1 | One-cycle command: clear divider mode and load the code |
| rollback_code_o | output | CODE_W | Frequency code to restore |

## Verification
Errors in the internal state show up at the ports quickly. A prescaler that is off by one moves the first count change by a cycle. A wrong count value shows on `count_o` within one tick. A stuck run flag shows up either as a missing expiry or as an extra rollback that the scoreboard did not expect. A faulty pulse counter makes `rst_pull_o` one cycle too short or too long, and sampling on the exact edge on both sides of the pulse catches either case. A wrong source choice shows as a wrong code on the first rollback after it.

// File: rtl/freq_watchdog.sv
module freq_watchdog #(
  parameter int TICK_CYCLES = 6_250_000,
  parameter int PULSE_TICKS = 1,
  parameter int CNT_W       = 8,
  parameter int CODE_W      = 5,
  parameter int INIT_LOAD   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              load_wr,
  input  logic [CNT_W-1:0]  load_wdata,
  input  logic              safe_sel,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] strap_code,
  output logic [CNT_W-1:0]  count_o,
  output logic              running_o,
  output logic              timeout_o,
  output logic              rst_pull_o,
  output logic              rollback_o,
  output logic [CODE_W-1:0] rollback_code_o
);
  localparam int PULSE_LEN = TICK_CYCLES * PULSE_TICKS;
  localparam int PRE_W = $clog2(TICK_CYCLES + 1);
  localparam int PUL_W = $clog2(PULSE_LEN + 1);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_CYCLES - 1);
  localparam logic [PUL_W-1:0] PUL_MAX = PUL_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0]  load_q, cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PUL_W-1:0]  pcnt_q;
  logic              run_q, to_q, pull_q, rb_q;
  logic [CODE_W-1:0] code_q;

  wire [CNT_W-1:0] next_load = load_wr ? load_wdata : load_q;
  wire start  = en_wr & en_wdata & (next_load != '0);
  wire tick   = run_q & ~load_wr & ~en_wr & (pre_q == PRE_MAX);
  wire expire = tick & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= CNT_W'(INIT_LOAD);
      cnt_q  <= CNT_W'(INIT_LOAD);
      pre_q  <= '0;
      run_q  <= 1'b0;
      to_q   <= 1'b0;
      rb_q   <= 1'b0;
      code_q <= '0;
    end else begin
      rb_q <= 1'b0;
      if (load_wr) load_q <= load_wdata;
      if (start) begin
        cnt_q <= next_load;
        pre_q <= '0;
        run_q <= 1'b1;
        to_q  <= 1'b0;
      end else if (load_wr || en_wr) begin
        if (load_wr) begin
          cnt_q <= load_wdata;
          pre_q <= '0;
        end
        if (en_wr || (load_wdata == '0)) run_q <= 1'b0;
      end else if (run_q) begin
        if (tick) begin
          pre_q <= '0;
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
        if (expire) begin
          run_q  <= 1'b0;
          to_q   <= 1'b1;
          rb_q   <= 1'b1;
          code_q <= safe_sel ? safe_code : strap_code;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
      pcnt_q <= '0;
    end else if (expire) begin
      pull_q <= 1'b1;
      pcnt_q <= PUL_MAX;
    end else if (pull_q) begin
      if (pcnt_q == '0) pull_q <= 1'b0;
      else pcnt_q <= pcnt_q - PUL_W'(1);
    end
  end

  assign count_o         = cnt_q;
  assign running_o       = run_q;
  assign timeout_o       = to_q;
  assign rst_pull_o      = pull_q;
  assign rollback_o      = rb_q;
  assign rollback_code_o = code_q;

  a_r5_pull_with_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (rst_pull_o && rollback_o));
  a_r5_pull_only_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pull_o && !rollback_o) |-> $past(rst_pull_o));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_o |=> !rollback_o);
  a_r3_idle_after_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_o |-> !running_o);
  a_r4_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !en_wr) |=> timeout_o);
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !load_wr && !en_wr) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - CNT_W'(1)));
  a_r10_zero_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && en_wr && load_wr && load_wdata == '0) |=> !running_o);
endmodule

// File: tb/freq_watchdog_tb.sv
module freq_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0, load_wr = 1'b0, safe_sel = 1'b0;
  logic [7:0] load_wdata = '0;
  logic [4:0] safe_code = 5'h0A, strap_code = 5'h13;
  logic [7:0] count_o;
  logic running_o, timeout_o, rst_pull_o, rollback_o;
  logic [4:0] rollback_code_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0] exp_q[$];

  freq_watchdog #(.TICK_CYCLES(TICK), .PULSE_TICKS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .load_wr(load_wr), .load_wdata(load_wdata), .safe_sel(safe_sel),
    .safe_code(safe_code), .strap_code(strap_code), .count_o(count_o),
    .running_o(running_o), .timeout_o(timeout_o), .rst_pull_o(rst_pull_o),
    .rollback_o(rollback_o), .rollback_code_o(rollback_code_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_load(input logic [7:0] v);
    load_wr = 1'b1; load_wdata = v; step(); load_wr = 1'b0;
  endtask

  task automatic write_en(input logic b);
    en_wr = 1'b1; en_wdata = b; step(); en_wr = 1'b0;
  endtask

  // monitor: every rollback must match the next expected code (R6, R7)
  always @(negedge clk) begin
    if (rst_n && rollback_o) begin
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected rollback", 1, 0);
      else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        check(rollback_code_o == e, "R6 rollback code", rollback_code_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(count_o == 8, "R1 count", count_o, 8);
    check(!running_o && !timeout_o, "R1 idle", {running_o, timeout_o}, 0);
    check(!rst_pull_o && !rollback_o, "R1 outputs", {rst_pull_o, rollback_o}, 0);

    // strap rollback, countdown walk
    safe_sel = 1'b0;
    write_load(8'd3);
    exp_q.push_back(5'h13);
    write_en(1'b1);
    check(running_o, "R3 running after start", running_o, 1);
    check(count_o == 3, "R2 count at start", count_o, 3);
    for (int k = 1; k <= 2; k++) begin
      repeat (TICK) step();
      check(count_o == 8'(3 - k), "R2 decrement", count_o, 3 - k);
      check(running_o, "R3 still running", running_o, 1);
    end
    repeat (TICK) step();
    check(count_o == 0, "R2 count zero", count_o, 0);
    check(!running_o, "R3 stop on expiry", running_o, 0);
    check(timeout_o, "R4 timeout set", timeout_o, 1);
    check(rst_pull_o, "R5 pull at expiry", rst_pull_o, 1);
    check(rollback_o, "R7 rollback pulse", rollback_o, 1);
    step();
    check(!rollback_o, "R7 single cycle", rollback_o, 0);
    repeat (8) step();
    check(rst_pull_o, "R5 pull last cycle", rst_pull_o, 1);
    step();
    check(!rst_pull_o, "R5 pull released", rst_pull_o, 0);
    repeat (10) step();
    check(timeout_o, "R4 sticky", timeout_o, 1);

    // safe code rollback, restart clears timeout
    safe_sel = 1'b1;
    write_load(8'd2);
    exp_q.push_back(5'h0A);
    write_en(1'b1);
    check(!timeout_o, "R4 cleared by start", timeout_o, 0);
    repeat (2 * TICK) step();
    check(timeout_o && count_o == 0, "R4 second expiry", timeout_o, 1);
    repeat (12) step();

    // kick reloads and restarts the period
    write_load(8'd3);
    write_en(1'b1);
    repeat (2 * TICK) step();
    check(count_o == 1, "R2 before kick", count_o, 1);
    write_load(8'd3);
    check(count_o == 3 && running_o, "R8 reload", count_o, 3);
    repeat (TICK - 1) step();
    check(count_o == 3, "R8 period restarted", count_o, 3);
    step();
    check(count_o == 2, "R8 first tick after kick", count_o, 2);

    // stop holds the count
    write_en(1'b0);
    check(!running_o, "R9 stopped", running_o, 0);
    repeat (50) step();
    check(count_o == 2, "R9 count held", count_o, 2);
    check(!timeout_o && !rst_pull_o, "R9 no expiry", {timeout_o, rst_pull_o}, 0);

    // zero period is ignored
    write_load(8'd0);
    write_en(1'b1);
    check(!running_o, "R10 no start", running_o, 1'b0);
    repeat (30) step();
    check(!running_o && count_o == 0, "R10 stays idle", running_o, 0);
    check(!timeout_o && !rst_pull_o, "R10 no expiry", timeout_o, 0);

    check(exp_q.size() == 0, "R6 all rollbacks seen", exp_q.size(), 0);
    finish_run();
  end
endmodule